// File: doc/BRIEF.md
# Modem Line Control and Status Registers

This block holds the modem-control register of a 16550-style serial controller and produces the modem-status register. The control register drives the terminal-ready and request-to-send pins, a general-purpose output, an interrupt-output enable and a loopback selector. The status side samples four external modem lines: clear-to-send, data-set-ready, ring and carrier-detect. Each line passes through a synchroniser. The status register then reports the level of each line together with a sticky change flag for it.

A read strobe on the status register clears the change flags on the following clock edge. A change that is detected in the same cycle as the read is kept. The OR of the four flags forms a modem-status interrupt request, which a separate prioritiser consumes. In loopback the control bits stand in for the external lines, and the two handshake output pins are forced inactive.

All ports are plain control and status pins. No data stream crosses this block, so there is no valid/ready handshake.

Top module: `modem_ctl_status`

## Requirements
- R1: A write strobe loads the 5-bit control register, which reads back on `ctl_q` from the next cycle. Bit 0 drives `dtr_out`, bit 1 drives `rts_out`, bit 2 drives `out1_out`, bit 3 drives `irq_en_out` and bit 4 selects loopback.
- R2: While control bit 4 is set, `dtr_out` and `rts_out` are low whatever bits 0 and 1 hold.
- R3: Status bits 7:4 carry the line levels in the order carrier (7), ring (6), data-set-ready (5) and clear-to-send (4). An external line change reaches its status bit after two rising clock edges.
- R4: In loopback the reported levels come from the control bits: clear-to-send from bit 1, data-set-ready from bit 0, ring from bit 2 and carrier from bit 3. The external lines are ignored.
- R5: Status bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier) are set one edge after any change in the reported level of that line.
- R6: Status bit 2 is set only when the reported ring level falls from 1 to 0. A rising ring level leaves it clear.
- R7: A change flag stays set until a read strobe is taken. It is clear from the edge after the read.
- R8: A change detected on the same edge that takes a read strobe leaves its flag set.
- R9: `msi_req` is high exactly when at least one of status bits 3:0 is set.
- R10: Entering or leaving loopback sets the change flags of every line whose reported level differs from its previous value.
- R11: After reset the control register, the change flags and all output pins are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control register write value |
| ctl_q | output | 5 | Control register contents |
| sts_re | input | 1 | Status register read strobe (clears flags) |
| sts_q | output | 8 | Status register value |
| cts_in | input | 1 | External clear-to-send, active high |
| dsr_in | input | 1 | External data-set-ready, active high |
| ri_in | input | 1 | External ring indicator, active high |
| dcd_in | input | 1 | External carrier detect, active high |
| dtr_out | output | 1 | Terminal-ready pin |
| rts_out | output | 1 | Request-to-send pin |
| out1_out | output | 1 | General-purpose output pin |
| irq_en_out | output | 1 | Interrupt-output enable |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that the external lines are low while reset is held. Otherwise the synchroniser would deliver a first level against a zero history and raise a flag at start-up. The bench therefore holds all four lines low through reset. After reset it lets the lines and strobes vary freely, so read strobes do fall on the same edge as detected changes. Loopback writes are mixed into the random phase, so the external lines are also exercised while they are masked.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int NLINES = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;

  typedef struct packed {
    logic loop;
    logic irq_en;
    logic out1;
    logic rts;
    logic dtr;
  } mctl_t;

  localparam int CTL_W = $bits(mctl_t);
  localparam int STS_W = 2 * NLINES;
endpackage

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) q[k] <= '0;
    end else begin
      q[0] <= din;
      for (int k = 1; k < STAGES; k++) q[k] <= q[k-1];
    end
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/modem_delta.sv
module modem_delta #(
  parameter int W      = 4,
  parameter int RI_IDX = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic         clr,
  output logic [W-1:0] flags,
  output logic         quiet
);
  logic [W-1:0] prev;
  logic [W-1:0] hit;

  generate
    for (genvar i = 0; i < W; i++) begin : g_edge
      if (i == RI_IDX) begin : g_trail
        assign hit[i] = prev[i] & ~lvl[i];
      end else begin : g_any
        assign hit[i] = prev[i] ^ lvl[i];
      end
    end
  endgenerate

  assign quiet = (hit == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev  <= '0;
      flags <= '0;
    end else begin
      prev  <= lvl;
      flags <= (flags & {W{~clr}}) | hit;
    end
  end

  // R7: without a read no flag drops
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));

  // R6: a high ring level cannot raise the ring flag
  a_r6_ri_rise_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[RI_IDX] && lvl[RI_IDX]) |=> !flags[RI_IDX]);

  // R5: a level change is always flagged on the next edge
  a_r5_cts_change: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[0] != prev[0]) |=> flags[0]);
endmodule

// File: rtl/modem_ctl_status.sv
module modem_ctl_status
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             sts_re,
  output logic [STS_W-1:0] sts_q,
  input  logic             cts_in,
  input  logic             dsr_in,
  input  logic             ri_in,
  input  logic             dcd_in,
  output logic             dtr_out,
  output logic             rts_out,
  output logic             out1_out,
  output logic             irq_en_out,
  output logic             msi_req
);
  mctl_t              ctl;
  logic [NLINES-1:0]  ext_raw, ext_syn, loop_lvl, lvl, flags;
  logic               quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) ctl <= '0;
    else if (ctl_we) ctl <= mctl_t'(ctl_wdata);
  end

  assign ext_raw[IDX_CTS] = cts_in;
  assign ext_raw[IDX_DSR] = dsr_in;
  assign ext_raw[IDX_RI]  = ri_in;
  assign ext_raw[IDX_DCD] = dcd_in;

  modem_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_raw), .dout(ext_syn));

  assign loop_lvl[IDX_CTS] = ctl.rts;
  assign loop_lvl[IDX_DSR] = ctl.dtr;
  assign loop_lvl[IDX_RI]  = ctl.out1;
  assign loop_lvl[IDX_DCD] = ctl.irq_en;
  assign lvl = ctl.loop ? loop_lvl : ext_syn;

  modem_delta #(.W(NLINES), .RI_IDX(IDX_RI)) u_delta (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .clr(sts_re),
    .flags(flags), .quiet(quiet));

  assign ctl_q      = ctl;
  assign sts_q      = {lvl, flags};
  assign dtr_out    = ctl.dtr & ~ctl.loop;
  assign rts_out    = ctl.rts & ~ctl.loop;
  assign out1_out   = ctl.out1;
  assign irq_en_out = ctl.irq_en;
  assign msi_req    = |flags;

  // R2: writing loopback silences the handshake pins next cycle
  a_r2_loop_pins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[CTL_W-1]) |=> (!dtr_out && !rts_out));

  // R9: a read with no new change drops the request
  a_r9_req_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_re && quiet) |=> !msi_req);
endmodule

// File: tb/test_modem_ctl_status.sv
module test_modem_ctl_status;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ctl_we, sts_re;
  logic [4:0] ctl_wdata, ctl_q;
  logic [7:0] sts_q;
  logic cts_in, dsr_in, ri_in, dcd_in;
  logic dtr_out, rts_out, out1_out, irq_en_out, msi_req;

  int n_chk = 0;
  int n_bad = 0;

  modem_ctl_status i_modem_ctl_status (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .sts_re(sts_re), .sts_q(sts_q),
    .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
    .dtr_out(dtr_out), .rts_out(rts_out), .out1_out(out1_out),
    .irq_en_out(irq_en_out), .msi_req(msi_req));

  // reference state: levels index 0 cts, 1 dsr, 2 ri, 3 dcd
  logic [3:0] m_s1, m_s2, m_prev, m_flags, lv, hit;
  logic [4:0] m_ctl;

  function automatic logic [3:0] sel_lvl(logic [4:0] c, logic [3:0] s);
    return c[4] ? {c[3], c[2], c[0], c[1]} : s;
  endfunction

  function automatic logic [3:0] edges(logic [3:0] now, logic [3:0] old);
    logic [3:0] e;
    e = now ^ old;
    e[2] = old[2] & ~now[2];
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_flags <= '0; m_ctl <= '0;
    end else begin
      lv = sel_lvl(m_ctl, m_s2);
      hit = edges(lv, m_prev);
      m_s1 <= {dcd_in, ri_in, dsr_in, cts_in};
      m_s2 <= m_s1;
      m_prev <= lv;
      m_flags <= (m_flags & {4{~sts_re}}) | hit;
      if (ctl_we) m_ctl <= ctl_wdata;
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "status", {24'd0, sts_q}, {24'd0, sel_lvl(m_ctl, m_s2), m_flags});
    chk(tag, "ctl", {27'd0, ctl_q}, {27'd0, m_ctl});
    chk(tag, "pins", {27'd0, dtr_out, rts_out, out1_out, irq_en_out, msi_req},
        {27'd0, m_ctl[0] & ~m_ctl[4], m_ctl[1] & ~m_ctl[4], m_ctl[2], m_ctl[3], |m_flags});
  endtask

  task automatic tick(string tag);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic rd_flags(string tag);
    sts_re = 1'b1; tick(tag); sts_re = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7421));
    rst_n = 1'b0; ctl_we = 1'b0; sts_re = 1'b0; ctl_wdata = '0;
    cts_in = 1'b0; dsr_in = 1'b0; ri_in = 1'b0; dcd_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "status", {24'd0, sts_q}, 32'd0);
    chk("R11", "pins", {27'd0, dtr_out, rts_out, out1_out, irq_en_out, msi_req}, 32'd0);
    chk("R11", "ctl", {27'd0, ctl_q}, 32'd0);

    // R1 control bits to pins
    ctl_we = 1'b1; ctl_wdata = 5'h0F; tick("R1"); ctl_we = 1'b0;
    chk("R1", "pins", {28'd0, dtr_out, rts_out, out1_out, irq_en_out}, 32'hF);

    // R3 synchroniser latency: visible after second edge
    cts_in = 1'b1; tick("R3");
    chk("R3", "cts after 1 edge", {31'd0, sts_q[4]}, 32'd0);
    tick("R3");
    chk("R3", "cts after 2 edges", {31'd0, sts_q[4]}, 32'd1);
    tick("R5");
    chk("R5", "cts flag", {31'd0, sts_q[0]}, 32'd1);
    chk("R9", "req", {31'd0, msi_req}, 32'd1);

    // R7 sticky, then read clears
    repeat (3) tick("R7");
    chk("R7", "flag held", {31'd0, sts_q[0]}, 32'd1);
    rd_flags("R7");
    chk("R7", "flag cleared", {28'd0, sts_q[3:0]}, 32'd0);
    chk("R9", "req low", {31'd0, msi_req}, 32'd0);

    // R6 ring rising: no flag; falling: flag
    ri_in = 1'b1; repeat (4) tick("R6");
    chk("R6", "ri rise", {31'd0, sts_q[2]}, 32'd0);
    ri_in = 1'b0; repeat (4) tick("R6");
    chk("R6", "ri fall", {31'd0, sts_q[2]}, 32'd1);
    rd_flags("R6");

    // R8 change coinciding with read is kept
    dsr_in = 1'b1; tick("R8"); tick("R8");
    sts_re = 1'b1; tick("R8"); sts_re = 1'b0;
    chk("R8", "dsr flag kept", {31'd0, sts_q[1]}, 32'd1);
    rd_flags("R8");

    // R4/R10/R2 loopback with rts=1, irq_en=1, dtr=0, out1=0
    ctl_we = 1'b1; ctl_wdata = 5'h1A; tick("R2"); ctl_we = 1'b0;
    chk("R2", "handshake pins", {30'd0, dtr_out, rts_out}, 32'd0);
    chk("R4", "loop levels", {28'd0, sts_q[7:4]}, 32'h9);
    cts_in = 1'b0; dsr_in = 1'b1; dcd_in = 1'b0; ri_in = 1'b1;
    tick("R10");
    chk("R10", "loop entry flags", {28'd0, sts_q[3:0]}, 32'hA);
    repeat (3) tick("R4");
    chk("R4", "external ignored", {28'd0, sts_q[7:4]}, 32'h9);
    rd_flags("R10");
    ctl_we = 1'b1; ctl_wdata = 5'h00; tick("R10"); ctl_we = 1'b0;
    tick("R10");
    chk("R10", "loop exit flags", {28'd0, sts_q[3:0]}, 32'hB);
    rd_flags("R10");

    // random phase: R1 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 3000; i++) begin
      {dcd_in, ri_in, dsr_in, cts_in} = 4'($urandom_range(0, 15));
      sts_re = ($urandom_range(0, 3) == 0);
      ctl_we = ($urandom_range(0, 15) == 0);
      ctl_wdata = 5'($urandom_range(0, 31));
      tick("R5 R7 R9 random");
    end
    ctl_we = 1'b0; sts_re = 1'b0;
    tick("R4 R10 random");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule